// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is a hardware state machine that retunes a clock PLL when it receives a request. It also keeps the divider between the core clock and the interface clock safe while the PLL changes. A request strobe carries two things: the target rate, and one set of PLL settings (input, feedback and output dividers, band, and a bypass flag). The block then works through a fixed order of register accesses on a simple single-cycle register port:

1. Raise the interface divider when the new rate is high.
2. Write the PLL control word. A bypass request uses read-modify-write instead.
3. Wait the lock interval.
4. Read the status word.
5. Lower the interface divider when the new rate is low and the lock succeeded.

At the end the block gives a one-cycle done pulse with a 2-bit result.

The lock interval is a cycle count equal to the lock time in microseconds times the clock frequency in MHz. The parameter `HAS_IFDIV` selects a variant with no interface divider, for general-purpose or video PLLs. That variant runs the same write, wait and check sequence and never touches the divider register. Choosing the PLL settings for a given rate happens outside this block.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `reg_we_o` and `reg_re_o` are all low, and no register write occurs until a request arrives.
- R2: For a non-bypass request, the control word written to address 0 has these fields, with every other bit zero (including bit 0, power-down, and bit 1, bypass):
  - output divider in bits 3:2
  - input divider in bits 8:4
  - feedback divider in bits 15:9
  - band in bits 23:20
- R3: For a bypass request, the block first reads address 0 and then writes back the value it read with bit 1 set. All other bits keep their read value.
- R4: When the target rate is above `RATE_TH` (500,000,000), value 1 (divide-by-2) is written to the interface divider register at address 2. This write happens before the control write.
- R5: The status register at address 1 is read exactly `LOCK_US*CLK_MHZ + 1` cycles after the cycle of the control write.
- R6: Status bit 0 is lock and bit 1 is error. The result codes are:
  - 1 (timeout) when lock is clear, whatever the error bit says.
  - 2 (error) when lock is set and error is set.
  - 0 (ok) otherwise.
- R7: When the target rate is at or below `RATE_TH` and the result is ok, value 0 (divide-by-1) is written to address 2 as the last write of the sequence. On timeout or error this write is skipped.
- R8: `busy_o` rises the cycle after an accepted request and stays high through the done cycle. A request that arrives while busy causes no register write and no extra done pulse.
- R9: `done_o` is a one-cycle pulse. `result_o` is valid in that cycle, and `busy_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_i | input | 1 | Retune request strobe |
| rate_i | input | 32 | Target rate in Hz |
| cfg_idiv_i | input | 5 | Input divider field |
| cfg_fbdiv_i | input | 7 | Feedback divider field |
| cfg_odiv_i | input | 2 | Output divider field |
| cfg_band_i | input | 4 | Band field |
| cfg_bypass_i | input | 1 | Request bypass instead of a new divider setting |
| reg_addr_o | output | 2 | Register address: 0 control, 1 status, 2 interface divider |
| reg_wdata_o | output | 32 | Write data |
| reg_we_o | output | 1 | Write enable |
| reg_re_o | output | 1 | Read strobe; `reg_rdata_i` is sampled in the same cycle |
| reg_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 error |

## Verification
The assertions check the following on every cycle:
- the exact distance between the control write and the status read
- that a timeout follows any status read without lock
- that a divide-by-1 write is always followed by an ok completion
- that writes happen only while busy
- that done is a single-cycle pulse

Only the bench scenarios can show the rest:
- the full order and contents of the writes for each rate, bypass and status combination
- the read-modify-write value
- that a request arriving during a sequence leaves the write log unchanged

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

  localparam int DATA_W  = 32;
  localparam int ODIV_W  = 2;
  localparam int IDIV_W  = 5;
  localparam int FBDIV_W = 7;
  localparam int BAND_W  = 4;

  // Field positions are decoded by the PLL control register.
  localparam int ODIV_LSB  = 2;
  localparam int IDIV_LSB  = 4;
  localparam int FBDIV_LSB = 9;
  localparam int BAND_LSB  = 20;
  localparam int BYP_BIT   = 1;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_IFDIV = 2'd2;

  localparam logic [DATA_W-1:0] IFDIV_BY2 = 32'h1;
  localparam logic [DATA_W-1:0] IFDIV_BY1 = 32'h0;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_ERROR   = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RAISE, S_RDCTRL, S_WRCTRL, S_WAIT, S_CHECK, S_LOWER, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic               bypass;
    logic [BAND_W-1:0]  band;
    logic [FBDIV_W-1:0] fbdiv;
    logic [IDIV_W-1:0]  idiv;
    logic [ODIV_W-1:0]  odiv;
  } pll_cfg_t;

endpackage

// File: rtl/pll_ctrl_word.sv
module pll_ctrl_word
  import pll_retune_pkg::*;
(
  input  pll_cfg_t          cfg_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] word_o
);

  always_comb begin
    word_o = '0;
    if (cfg_i.bypass) begin
      word_o          = old_i;
      word_o[BYP_BIT] = 1'b1;
    end else begin
      word_o[ODIV_LSB  +: ODIV_W]  = cfg_i.odiv;
      word_o[IDIV_LSB  +: IDIV_W]  = cfg_i.idiv;
      word_o[FBDIV_LSB +: FBDIV_W] = cfg_i.fbdiv;
      word_o[BAND_LSB  +: BAND_W]  = cfg_i.band;
    end
  end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic last_o
);

  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (en_i && (cnt_q != '0));
    cnt_d  = load_i ? LOAD_VAL : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = en_i && (cnt_q == ONE);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_retune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              hi_i,
  input  logic              lo_i,
  input  pll_cfg_t          cfg_i,
  input  logic [DATA_W-1:0] ctrl_word_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              tmr_last_i,
  output logic              tmr_load_o,
  output logic              tmr_en_o,
  output pll_cfg_t          cfg_q_o,
  output logic [DATA_W-1:0] old_q_o,
  output logic [1:0]        addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);

  seq_state_e st_q, st_d;
  logic       hi_q, lo_q;
  res_e       res_q, res_d;
  logic       cap_en, old_en, res_en;

  // Next-state and output decode
  always_comb begin
    st_d       = st_q;
    res_d      = res_q;
    cap_en     = 1'b0;
    old_en     = 1'b0;
    res_en     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_en_o   = 1'b0;
    addr_o     = ADDR_CTRL;
    wdata_o    = '0;
    we_o       = 1'b0;
    re_o       = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_i) begin
        cap_en = 1'b1;
        if (hi_i)              st_d = S_RAISE;
        else if (cfg_i.bypass) st_d = S_RDCTRL;
        else                   st_d = S_WRCTRL;
      end
      S_RAISE: begin
        addr_o  = ADDR_IFDIV;
        wdata_o = IFDIV_BY2;
        we_o    = 1'b1;
        st_d    = cfg_q_o.bypass ? S_RDCTRL : S_WRCTRL;
      end
      S_RDCTRL: begin
        addr_o = ADDR_CTRL;
        re_o   = 1'b1;
        old_en = 1'b1;
        st_d   = S_WRCTRL;
      end
      S_WRCTRL: begin
        addr_o     = ADDR_CTRL;
        wdata_o    = ctrl_word_i;
        we_o       = 1'b1;
        tmr_load_o = 1'b1;
        st_d       = S_WAIT;
      end
      S_WAIT: begin
        tmr_en_o = 1'b1;
        if (tmr_last_i) st_d = S_CHECK;
      end
      S_CHECK: begin
        addr_o = ADDR_STAT;
        re_o   = 1'b1;
        res_en = 1'b1;
        // Lock is judged before the error bit.
        if (!rdata_i[0]) begin
          res_d = RES_TIMEOUT;
          st_d  = S_DONE;
        end else if (rdata_i[1]) begin
          res_d = RES_ERROR;
          st_d  = S_DONE;
        end else begin
          res_d = RES_OK;
          st_d  = lo_q ? S_LOWER : S_DONE;
        end
      end
      S_LOWER: begin
        addr_o  = ADDR_IFDIV;
        wdata_o = IFDIV_BY1;
        we_o    = 1'b1;
        st_d    = S_DONE;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cfg_q_o <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      old_q_o <= '0;
      res_q   <= RES_OK;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        cfg_q_o <= cfg_i;
        hi_q    <= hi_i;
        lo_q    <= lo_i;
      end
      if (old_en) old_q_o <= rdata_i;
      if (res_en) res_q   <= res_d;
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = (st_q == S_DONE);
  assign result_o = res_q;

  logic unused_hi;
  assign unused_hi = hi_q;

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int          CLK_MHZ   = 50,
  parameter int          LOCK_US   = 100,
  parameter logic [31:0] RATE_TH   = 32'd500_000_000,
  parameter bit          HAS_IFDIV = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [31:0]        rate_i,
  input  logic [4:0]         cfg_idiv_i,
  input  logic [6:0]         cfg_fbdiv_i,
  input  logic [1:0]         cfg_odiv_i,
  input  logic [3:0]         cfg_band_i,
  input  logic               cfg_bypass_i,
  output logic [1:0]         reg_addr_o,
  output logic [31:0]        reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [31:0]        reg_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         result_o
);

  localparam int LOCK_CYCLES = CLK_MHZ * LOCK_US;

  pll_cfg_t          cfg_in, cfg_q;
  logic [DATA_W-1:0] old_q, ctrl_word;
  logic              hi_now, lo_now;
  logic              tmr_load, tmr_en, tmr_last;

  assign cfg_in = '{bypass: cfg_bypass_i, band: cfg_band_i, fbdiv: cfg_fbdiv_i,
                    idiv: cfg_idiv_i, odiv: cfg_odiv_i};

  generate
    if (HAS_IFDIV) begin : g_ifdiv
      assign hi_now = (rate_i >  RATE_TH);
      assign lo_now = (rate_i <= RATE_TH);
    end else begin : g_no_ifdiv
      assign hi_now = 1'b0;
      assign lo_now = 1'b0;
    end
  endgenerate

  pll_seq_fsm u_fsm (
    .clk, .rst_n, .req_i,
    .hi_i(hi_now), .lo_i(lo_now), .cfg_i(cfg_in),
    .ctrl_word_i(ctrl_word), .rdata_i(reg_rdata_i),
    .tmr_last_i(tmr_last), .tmr_load_o(tmr_load), .tmr_en_o(tmr_en),
    .cfg_q_o(cfg_q), .old_q_o(old_q),
    .addr_o(reg_addr_o), .wdata_o(reg_wdata_o), .we_o(reg_we_o), .re_o(reg_re_o),
    .busy_o, .done_o, .result_o
  );

  pll_lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
    .clk, .rst_n, .load_i(tmr_load), .en_i(tmr_en), .last_o(tmr_last)
  );

  pll_ctrl_word u_word (.cfg_i(cfg_q), .old_i(old_q), .word_o(ctrl_word));

endmodule

// File: rtl/pll_retune_chk.sv
module pll_retune_chk #(
  parameter int LOCK_CYCLES = 5000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [1:0]  result_o,
  input logic [1:0]  reg_addr_o,
  input logic [31:0] reg_wdata_o,
  input logic        reg_we_o,
  input logic        reg_re_o,
  input logic [31:0] reg_rdata_i
);

  logic [31:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              since_wr <= '0;
    else if (reg_we_o && reg_addr_o == 2'd0) since_wr <= 32'd1;
    else if (since_wr != '0)                 since_wr <= since_wr + 32'd1;
  end

  p_we_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o || reg_re_o) |-> busy_o);

  p_raise_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_addr_o == 2'd2) |-> (reg_wdata_o <= 32'd1));

  p_lock_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re_o && reg_addr_o == 2'd1) |-> (since_wr == 32'(LOCK_CYCLES + 1)));

  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re_o && reg_addr_o == 2'd1 && !reg_rdata_i[0]) |=> (done_o && result_o == 2'd1));

  p_lower_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_addr_o == 2'd2 && reg_wdata_o == 32'd0) |=> (done_o && result_o == 2'd0));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i) |=> busy_o);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

endmodule

bind pll_retune_seq pll_retune_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk, .rst_n, .req_i, .busy_o, .done_o, .result_o,
  .reg_addr_o, .reg_wdata_o, .reg_we_o, .reg_re_o, .reg_rdata_i
);

// File: tb/tb_pll_retune_seq.sv
module tb_pll_retune_seq;

  localparam int CLK_MHZ = 50;
  localparam int LOCK_US = 1;
  localparam int L       = CLK_MHZ * LOCK_US;
  localparam logic [31:0] TH = 32'd500_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_i = 1'b0;
  logic [31:0] rate_i = '0;
  logic [4:0]  idiv = '0;
  logic [6:0]  fbdiv = '0;
  logic [1:0]  odiv = '0;
  logic [3:0]  band = '0;
  logic        byp = 1'b0;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        we, re, busy, done;
  logic [1:0]  result;

  pll_retune_seq #(.CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US)) dut (
    .clk, .rst_n, .req_i, .rate_i,
    .cfg_idiv_i(idiv), .cfg_fbdiv_i(fbdiv), .cfg_odiv_i(odiv),
    .cfg_band_i(band), .cfg_bypass_i(byp),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re),
    .reg_rdata_i(rdata), .busy_o(busy), .done_o(done), .result_o(result)
  );

  // PLL register stub
  logic        st_lock = 1'b0, st_err = 1'b0;
  logic        preset_en = 1'b0, clr = 1'b0;
  logic [31:0] preset_val = '0;
  logic [31:0] ctrl_reg = '0, ifdiv_reg = '0;
  logic [31:0] cyc = '0, ctrl_cyc = '0, stat_cyc = '0;
  logic [1:0]  log_a [8];
  logic [31:0] log_d [8];
  int          log_n = 0, done_n = 0;

  assign rdata = (addr == 2'd0) ? ctrl_reg :
                 (addr == 2'd1) ? {30'd0, st_err, st_lock} : ifdiv_reg;

  always @(posedge clk) begin
    cyc <= cyc + 32'd1;
    if (preset_en) ctrl_reg <= preset_val;
    if (clr) begin
      log_n  <= 0;
      done_n <= 0;
    end else begin
      if (we) begin
        if (log_n < 8) begin
          log_a[log_n] <= addr;
          log_d[log_n] <= wdata;
        end
        log_n <= log_n + 1;
        if (addr == 2'd0) begin ctrl_reg <= wdata; ctrl_cyc <= cyc; end
        if (addr == 2'd2) ifdiv_reg <= wdata;
      end
      if (re && addr == 2'd1) stat_cyc <= cyc;
      if (done) done_n <= done_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input int k, input logic [31:0] rate, input logic bp,
                          input logic lk, input logic er);
    logic [1:0]  ea [8];
    logic [31:0] ed [8];
    int          en;
    logic [31:0] pre, word;
    logic [1:0]  eres;
    bit          seen;
    pre = 32'h0F30_0001 ^ (32'(k) << 12);
    @(negedge clk);
    preset_en = 1'b1; preset_val = pre; clr = 1'b1;
    st_lock = lk; st_err = er;
    @(negedge clk);
    preset_en = 1'b0; clr = 1'b0;
    rate_i = rate; byp = bp;
    odiv = 2'(k % 4); idiv = 5'((k * 7) % 32);
    fbdiv = 7'((k * 13 + 5) % 128); band = 4'(k % 16);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk("R8 busy after request", 32'(busy), 32'd1);
    // expected write sequence
    en = 0;
    if (rate > TH) begin ea[en] = 2'd2; ed[en] = 32'd1; en++; end
    if (bp) word = pre | 32'h2;
    else word = (32'(band) << 20) | (32'(fbdiv) << 9) | (32'(idiv) << 4) | (32'(odiv) << 2);
    ea[en] = 2'd0; ed[en] = word; en++;
    if (!lk) eres = 2'd1;
    else if (er) eres = 2'd2;
    else eres = 2'd0;
    if (eres == 2'd0 && rate <= TH) begin ea[en] = 2'd2; ed[en] = 32'd0; en++; end
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (i == 6) begin
        req_i = 1'b1; rate_i = 32'd1_600_000_000; byp = ~bp; odiv = ~odiv;
      end else begin
        req_i = 1'b0;
      end
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    req_i = 1'b0;
    chk("R9 done seen", 32'(seen), 32'd1);
    chk("R6 result code", 32'(result), 32'(eres));
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R9 idle after done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R8 writes with busy request ignored", 32'(log_n), 32'(en));
    chk("R8 single done", 32'(done_n), 32'd1);
    for (int j = 0; j < en && j < log_n; j++) begin
      if (ed[j] == 32'd1 && ea[j] == 2'd2) begin
        chk("R4 raise address", 32'(log_a[j]), 32'(ea[j]));
        chk("R4 raise value", log_d[j], ed[j]);
      end else if (ea[j] == 2'd0) begin
        chk("R2 R3 control address", 32'(log_a[j]), 32'd0);
        if (bp) chk("R3 bypass read-modify-write", log_d[j], ed[j]);
        else    chk("R2 control word", log_d[j], ed[j]);
      end else begin
        chk("R7 lower address", 32'(log_a[j]), 32'd2);
        chk("R7 lower value", log_d[j], 32'd0);
      end
    end
    chk("R5 lock wait", stat_cyc - ctrl_cyc, 32'(L + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rates [4];
    int k;
    rates[0] = 32'd100_000_000; rates[1] = TH;
    rates[2] = TH + 32'd1;       rates[3] = 32'd1_600_000_000;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 no access after reset", 32'({we, re}), 32'd0);
    chk("R1 no writes logged", 32'(log_n), 32'd0);
    k = 0;
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 4; s++) begin
          run_case(k, rates[r], b[0], s[0], s[1]);
          k++;
        end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule